// File: doc/BRIEF.md
# ALU Status Flag Unit

This block pairs an 8-bit arithmetic/logic datapath with a status register of five arithmetic flags: negative, overflow, zero, digit carry and carry. The caller presents an operation code, two operands (`opnd_a` and `opnd_b`), a bit selector and a 5-bit flag-enable mask. The datapath computes the result combinationally. On the next rising clock edge, the status register takes the new flag values for the enabled flags. The operation only takes effect when `op_valid` is high.

The status register can also be the destination of an operation, as any ordinary register can. Flag-producing logic has priority over the data write. When an operation that affects flags targets the status register, none of the five flag bits takes the result data. The enabled flags take their computed values and the others keep their values. Bit set, bit clear, nibble swap and the two move operations never produce flags, so they write the register as plain data. Subtraction adds the two's complement of `opnd_a` to `opnd_b`, so carry and digit carry read 1 for "no borrow".

Top module: `alu_status_unit`

## Requirements
- R1: `status` places N at bit 4, OV at bit 3, Z at bit 2, DC at bit 1 and C at bit 0. Bits 7 to 5 always read 0. Reset clears all five flags to 0. The flag-enable mask uses the same bit order.
- R2: The opcodes are 0 ADD (b+a), 1 SUB (b-a), 2 INC (b+1), 3 DEC (b-1), 4 AND, 5 OR, 6 XOR and 7 CLR (result 0). For ADD, INC and DEC, C is the carry out of bit 7, DC is the carry out of bit 3 and OV flags a signed two's-complement overflow. The logic ops and CLR produce C, DC and OV as 0.
- R3: SUB sets C to 1 exactly when b >= a as unsigned values. It sets DC to 1 exactly when b[3:0] >= a[3:0]. OV flags a signed overflow of b-a.
- R4: When enabled, N takes result bit 7 and Z is 1 exactly when the result is zero.
- R5: Opcode 8 (rotate left through carry) gives {b[6:0],C} and produces C=b[7], DC=b[3]. Opcode 9 (rotate right through carry) gives {C,b[7:1]} and produces C=b[0], DC=b[4]. Both produce OV as 0.
- R6: For a flag-producing op that does not target the status register, enabled flags update and disabled flags keep their value.
- R7: A flag-producing op with a non-zero mask that targets the status register (`dest_status`=1) writes no result data into any flag. Enabled flags take their computed values and the rest hold. A CLR with only Z enabled therefore gives 000uu1uu.
- R8: The non-flag ops are 10 bit set (b with bit `bit_sel` set), 11 bit clear, 12 nibble swap, 13 move b and 14 move a (15 also moves a). They ignore the mask and never change a flag unless they target the status register. When they do, the status register takes result[4:0].
- R9: A flag-producing op with an all-zero mask that targets the status register writes result[4:0] into the flags.
- R10: While `op_valid` is low, the status register holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | Operation takes effect this cycle |
| op_code | input | 4 | Operation code (see R2, R5, R8) |
| opnd_a | input | 8 | Working operand |
| opnd_b | input | 8 | Register operand |
| bit_sel | input | 3 | Bit index for bit set / bit clear |
| flag_en | input | 5 | Per-flag update enable, status bit order |
| dest_status | input | 1 | The result is written to the status register |
| result | output | 8 | Combinational operation result |
| status | output | 8 | Status register contents |

## Verification
A wrong flag only shows at the `status` port one edge after the faulty operation. The same flag also feeds back through carry into the next rotate result, so a corrupted C reaches `result` one operation later. A write that wrongly leaks into the status register shows up as flags that change on a CLR or on a masked flag. A missed update shows up as a flag that fails to track result bit 7 or result zero. The stimulus mixes random operations, masks and destinations with directed borrow, overflow, rotate and status-destination cases. Each operation is compared against its expected result and status in the cycle after it.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int DW = 8;
  localparam int NF = 5;
  localparam int SELW = $clog2(DW);
  localparam int FN = 4;
  localparam int FOV = 3;
  localparam int FZ = 2;
  localparam int FDC = 1;
  localparam int FC = 0;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_INC = 4'd2, OP_DEC = 4'd3,
    OP_AND = 4'd4, OP_IOR = 4'd5, OP_XOR = 4'd6, OP_CLR = 4'd7,
    OP_RLC = 4'd8, OP_RRC = 4'd9, OP_BSET = 4'd10, OP_BCLR = 4'd11,
    OP_SWAP = 4'd12, OP_MOVB = 4'd13, OP_MOVA = 4'd14, OP_MOVX = 4'd15
  } op_e;

  function automatic logic makes_flags(op_e op);
    return (op <= OP_RRC);
  endfunction
endpackage

// File: rtl/alu_core.sv
module alu_core
  import alu_flag_pkg::*;
(
  input  op_e              op,
  input  logic [DW-1:0]    a,
  input  logic [DW-1:0]    b,
  input  logic [SELW-1:0]  sel,
  input  logic             c_in,
  output logic [DW-1:0]    res,
  output logic [NF-1:0]    flg
);
  localparam int HW = DW / 2;

  logic [DW-1:0] addend;
  logic          cin;
  logic          is_add;
  logic [HW:0]   lo_sum;
  logic [DW:0]   full_sum;
  logic [DW-1:0] onehot;

  always_comb begin
    addend = '0;
    cin    = 1'b0;
    is_add = 1'b1;
    case (op)
      OP_ADD:  addend = a;
      OP_SUB:  begin addend = ~a; cin = 1'b1; end
      OP_INC:  addend = DW'(1);
      OP_DEC:  addend = '1;
      default: is_add = 1'b0;
    endcase
  end

  assign lo_sum   = {1'b0, b[HW-1:0]} + {1'b0, addend[HW-1:0]} + {{HW{1'b0}}, cin};
  assign full_sum = {1'b0, b} + {1'b0, addend} + {{DW{1'b0}}, cin};
  assign onehot   = DW'(1) << sel;

  always_comb begin
    case (op)
      OP_AND:  res = a & b;
      OP_IOR:  res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CLR:  res = '0;
      OP_RLC:  res = {b[DW-2:0], c_in};
      OP_RRC:  res = {c_in, b[DW-1:1]};
      OP_BSET: res = b | onehot;
      OP_BCLR: res = b & ~onehot;
      OP_SWAP: res = {b[HW-1:0], b[DW-1:HW]};
      OP_MOVB: res = b;
      OP_MOVA: res = a;
      OP_MOVX: res = a;
      default: res = full_sum[DW-1:0];
    endcase
  end

  always_comb begin
    flg      = '0;
    flg[FN]  = res[DW-1];
    flg[FZ]  = (res == '0);
    if (is_add) begin
      flg[FC]  = full_sum[DW];
      flg[FDC] = lo_sum[HW];
      flg[FOV] = (b[DW-1] == addend[DW-1]) && (res[DW-1] != b[DW-1]);
    end else if (op == OP_RLC) begin
      flg[FC]  = b[DW-1];
      flg[FDC] = b[HW-1];
    end else if (op == OP_RRC) begin
      flg[FC]  = b[0];
      flg[FDC] = b[HW];
    end
  end
endmodule

// File: rtl/status_reg_ctl.sv
module status_reg_ctl
  import alu_flag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          flag_op,
  input  logic          dest_status,
  input  logic [NF-1:0] flag_en,
  input  logic [NF-1:0] wr_data,
  input  logic [NF-1:0] flag_val,
  output logic [NF-1:0] stat_q
);
  logic [NF-1:0] eff_mask;
  logic [NF-1:0] stat_d;
  logic          stat_ce;

  always_comb begin
    eff_mask = flag_op ? flag_en : '0;
    stat_ce  = op_valid;
    if (eff_mask != '0)
      stat_d = (eff_mask & flag_val) | (~eff_mask & stat_q);
    else if (dest_status)
      stat_d = wr_data;
    else
      stat_d = stat_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      stat_q <= '0;
    else if (stat_ce)
      stat_q <= stat_d;
  end

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(stat_q));

  assert_mask_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flag_op && !dest_status && !flag_en[FOV]) |=> stat_q[FOV] == $past(stat_q[FOV]));

  assert_suppress_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && flag_op && dest_status && (flag_en != '0))
      |=> ((stat_q & ~$past(flag_en)) == ($past(stat_q) & ~$past(flag_en))));

  assert_noflag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !flag_op && !dest_status) |=> $stable(stat_q));

  assert_raw_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && dest_status && (!flag_op || flag_en == '0)) |=> stat_q == $past(wr_data));
endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_flag_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [3:0]      op_code,
  input  logic [DW-1:0]   opnd_a,
  input  logic [DW-1:0]   opnd_b,
  input  logic [SELW-1:0] bit_sel,
  input  logic [NF-1:0]   flag_en,
  input  logic            dest_status,
  output logic [DW-1:0]   result,
  output logic [DW-1:0]   status
);
  localparam int SYNC = 2;

  logic [SYNC-1:0] rst_pipe;
  logic            rst_int_n;
  op_e             op;
  logic [NF-1:0]   flag_val;
  logic [NF-1:0]   stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rst_pipe <= '0;
    else
      rst_pipe <= {rst_pipe[SYNC-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC-1];

  assign op = op_e'(op_code);

  alu_core u_core (
    .op   (op),
    .a    (opnd_a),
    .b    (opnd_b),
    .sel  (bit_sel),
    .c_in (stat_q[FC]),
    .res  (result),
    .flg  (flag_val)
  );

  status_reg_ctl u_stat (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .op_valid    (op_valid),
    .flag_op     (makes_flags(op)),
    .dest_status (dest_status),
    .flag_en     (flag_en),
    .wr_data     (result[NF-1:0]),
    .flag_val    (flag_val),
    .stat_q      (stat_q)
  );

  assign status = {{(DW-NF){1'b0}}, stat_q};

  assert_neg_track_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && makes_flags(op) && flag_en[FN]) |=> status[FN] == $past(result[DW-1]));

  assert_zero_track_R4: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && makes_flags(op) && flag_en[FZ]) |=> status[FZ] == ($past(result) == '0));

  assert_borrow_R3: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && op == OP_SUB && flag_en[FC]) |=> status[FC] == ($past(opnd_b) >= $past(opnd_a)));

  assert_rot_carry_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (op_valid && op == OP_RLC && flag_en[FC]) |=> status[FC] == $past(opnd_b[DW-1]));
endmodule

// File: tb/sim_alu_status_unit.sv
module sim_alu_status_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = '0;
  logic [7:0] opnd_a = '0;
  logic [7:0] opnd_b = '0;
  logic [2:0] bit_sel = '0;
  logic [4:0] flag_en = '0;
  logic       dest_status = 1'b0;
  logic [7:0] result;
  logic [7:0] status;

  int total = 0;
  int bad = 0;
  logic [4:0] exp_st;

  alu_status_unit u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .bit_sel(bit_sel), .flag_en(flag_en),
    .dest_status(dest_status), .result(result), .status(status)
  );

  always #2 clk = ~clk;

  // returns {result[7:0], N, OV, Z, DC, C}
  function automatic logic [12:0] ref_op(logic [3:0] op, logic [7:0] a, logic [7:0] b,
                                         logic [2:0] s, logic c);
    logic [7:0] r; logic n, v, z, d, cy;
    r = 8'h00; v = 1'b0; d = 1'b0; cy = 1'b0;
    case (op)
      4'd0: begin r = b + a; cy = (9'(b) + 9'(a)) > 9'd255;
                  d = (5'(b[3:0]) + 5'(a[3:0])) > 5'd15;
                  v = (a[7] == b[7]) && (r[7] != b[7]); end
      4'd1: begin r = b - a; cy = (b >= a); d = (b[3:0] >= a[3:0]);
                  v = (a[7] != b[7]) && (r[7] != b[7]); end
      4'd2: begin r = b + 8'd1; cy = (b == 8'hFF); d = (b[3:0] == 4'hF); v = (b == 8'h7F); end
      4'd3: begin r = b - 8'd1; cy = (b != 8'h00); d = (b[3:0] != 4'h0); v = (b == 8'h80); end
      4'd4: r = a & b;
      4'd5: r = a | b;
      4'd6: r = a ^ b;
      4'd7: r = 8'h00;
      4'd8: begin r = {b[6:0], c}; cy = b[7]; d = b[3]; end
      4'd9: begin r = {c, b[7:1]}; cy = b[0]; d = b[4]; end
      4'd10: r = b | (8'h01 << s);
      4'd11: r = b & ~(8'h01 << s);
      4'd12: r = {b[3:0], b[7:4]};
      4'd13: r = b;
      default: r = a;
    endcase
    n = r[7]; z = (r == 8'h00);
    return {r, n, v, z, d, cy};
  endfunction

  function automatic logic [4:0] ref_next(logic [3:0] op, logic [4:0] st, logic [4:0] en,
                                          logic dst, logic [12:0] rf);
    logic [4:0] m;
    m = (op <= 4'd9) ? en : 5'b0;
    if (m != 5'b0) return (m & rf[4:0]) | (~m & st);
    if (dst) return rf[9:5];
    return st;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  // called right after a falling edge; returns right after the next falling edge
  task automatic do_op(string rq_res, string rq_st, logic [3:0] op, logic [7:0] a,
                       logic [7:0] b, logic [2:0] s, logic [4:0] en, logic dst);
    logic [12:0] rf;
    op_valid = 1'b1; op_code = op; opnd_a = a; opnd_b = b; bit_sel = s;
    flag_en = en; dest_status = dst;
    rf = ref_op(op, a, b, s, exp_st[0]);
    #1 check(rq_res, result, rf[12:5]);
    exp_st = ref_next(op, exp_st, en, dst, rf);
    @(negedge clk);
    check(rq_st, status, {3'b000, exp_st});
  endtask

  task automatic set_status(logic [4:0] v);
    do_op("R8", "R8", 4'd14, {3'b000, v}, 8'h00, 3'd0, 5'h1F, 1'b1);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    exp_st = 5'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 reset", status, 8'h00);

    // R2 add with carry, digit carry and overflow
    do_op("R2", "R2", 4'd0, 8'h48, 8'h48, 3'd0, 5'h1F, 1'b0);
    do_op("R2", "R2", 4'd0, 8'hFF, 8'h01, 3'd0, 5'h1F, 1'b0);
    do_op("R2", "R2", 4'd3, 8'h00, 8'h80, 3'd0, 5'h1F, 1'b0);
    do_op("R2", "R2", 4'd2, 8'h00, 8'hFF, 3'd0, 5'h1F, 1'b0);
    // R3 borrow polarity
    do_op("R3", "R3", 4'd1, 8'h05, 8'h05, 3'd0, 5'h1F, 1'b0);
    do_op("R3", "R3", 4'd1, 8'h06, 8'h05, 3'd0, 5'h1F, 1'b0);
    do_op("R3", "R3", 4'd1, 8'h01, 8'h80, 3'd0, 5'h1F, 1'b0);
    // R4 negative / zero
    do_op("R4", "R4", 4'd6, 8'hA5, 8'hA5, 3'd0, 5'h14, 1'b0);
    do_op("R4", "R4", 4'd5, 8'h80, 8'h01, 3'd0, 5'h14, 1'b0);
    // R5 rotates through carry, chained
    set_status(5'b00001);
    do_op("R5", "R5", 4'd8, 8'h00, 8'h48, 3'd0, 5'h03, 1'b0);
    do_op("R5", "R5", 4'd9, 8'h00, 8'h11, 3'd0, 5'h03, 1'b0);
    do_op("R5", "R5", 4'd9, 8'h00, 8'h00, 3'd0, 5'h03, 1'b0);
    // R6 masked flags hold
    set_status(5'b01010);
    do_op("R6", "R6", 4'd0, 8'h7F, 8'h7F, 3'd0, 5'h01, 1'b0);
    // R7 clear of status register gives 000uu1uu
    set_status(5'b11011);
    do_op("R7", "R7 clr", 4'd7, 8'h00, 8'h00, 3'd0, 5'h04, 1'b1);
    check("R7 pattern", status, 8'h1F);
    do_op("R7", "R7", 4'd0, 8'h00, 8'h00, 3'd0, 5'h05, 1'b1);
    // R8 non-flag ops
    do_op("R8", "R8", 4'd12, 8'hFF, 8'h3C, 3'd0, 5'h1F, 1'b0);
    do_op("R8", "R8", 4'd10, 8'h00, 8'h00, 3'd3, 5'h1F, 1'b1);
    do_op("R8", "R8", 4'd11, 8'h00, 8'h1F, 3'd1, 5'h00, 1'b1);
    // R9 zero mask, status destination
    do_op("R9", "R9", 4'd0, 8'h03, 8'h10, 3'd0, 5'h00, 1'b1);
    // R10 idle hold
    op_valid = 1'b0; opnd_b = 8'hFF; flag_en = 5'h1F; dest_status = 1'b1;
    @(negedge clk);
    check("R10", status, {3'b000, exp_st});

    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      op = 4'($urandom_range(0, 15));
      if (($urandom & 7) == 0) begin
        op_valid = 1'b0; flag_en = 5'($urandom);
        @(negedge clk);
        check("R10 rand", status, {3'b000, exp_st});
      end else begin
        do_op("R2 rand", "R6 rand", op, 8'($urandom), 8'($urandom), 3'($urandom),
              5'($urandom), ($urandom & 3) == 0);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule